// File: doc/BRIEF.md
# Framed Serial Bus Converter Readout Slave

This block is a slave on a framed serial bus, where each frame is 10 bits wide. The top two bits of a frame give its kind and the low eight bits carry a payload. A control frame loads a control byte. The control byte names an operation (select, write or read) and a register address. Data frames that follow then write that register, and read strobes return a byte from it. The bit-serial line coding sits outside the block. The block sees whole frames on a parallel input with a valid strobe, and it answers a read strobe with a registered byte on the following cycle.

The register file holds three configuration registers. One picks which of four analogue sources feeds the result path. Another picks whether a read of the converter register returns the low byte or the high nibble. The 12-bit converter sample arrives on an input port and is presented as two byte-wide pieces: a low byte with its top bit inverted, and a high nibble that appears only when high mode is set. Exactly one select code answers with an identification byte. A status register reports a cold-start flag and a power-fail flag, both taken from input pins.

Top module: `fsb_adc_slave`

## Requirements
- R1: Frame bits 9:8 give the frame kind: 00 is null, 01 is control and 10 is data. Kind 11 is ignored and changes no state.
- R2: A null frame clears the control byte and all configuration registers to zero.
- R3: A control frame stores bits 7:0 as the control byte. Control bits 7:6 give the operation (01 select, 10 write, 11 read, 00 none) and bits 3:0 give the register address.
- R4: A read strobe while the operation is select returns 0x80 when the control byte is exactly 0x43, and returns 0x00 for any other select byte.
- R5: Bits 7:6 of the register at address 2 pick the sample source: 0 is the converter input port, 1 reads as zero, and 2 and 3 read as full scale 0x7FF.
- R6: When bit 2 of the register at address 7 is clear, a read of address 0 returns bits 7:0 of the selected sample with bit 7 inverted.
- R7: When bit 2 of the register at address 7 is set, a read of address 0 returns bits 11:8 of the selected sample in bits 3:0, with bits 7:4 zero.
- R8: With the write operation selected, a data frame writes its payload to the register at address 1, 2 or 7. Address 7 keeps only payload bits 2:1 and stores zero in its other bits. Reads of addresses 1, 2 and 7 return the stored values.
- R9: A read of address 0x0D returns a status byte with the cold-start input in bit 0, the power-fail input in bit 1, and zero in bits 7:2.
- R10: Reads of any other address return 0x00. A data frame that arrives while the operation is not write changes no register, and a write to an address other than 1, 2 or 7 changes no register.
- R11: Read data is zero after reset. It takes its new value in the cycle after a read strobe and holds that value until the next strobe. A read strobe with operation none returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame present on frm_data this cycle |
| frm_data | input | 10 | Frame: kind in bits 9:8, payload in bits 7:0 |
| rd_strobe | input | 1 | Read request for the current control byte |
| conv_sample | input | 12 | Sample from the analogue converter |
| cold_start | input | 1 | Cold-start flag reported in status |
| power_fail | input | 1 | Power-fail flag reported in status |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_strobe |

## Verification
The bench builds the block with its default parameters: a 12-bit sample, an 8-bit payload and a 4-bit address. At these sizes the bench can afford exhaustive sweeps. It reads all 16 register addresses, tries all 64 select-operation control bytes, writes all 256 payloads to the address-7 register, and crosses the four sources and two read modes with a dense stride through the 4096 sample codes. The bench computes every expected byte arithmetically from the sample and the configuration. It also checks the no-effect cases: the reserved frame kind, data frames outside the write operation, and writes to unmapped addresses.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [1:0] {
    FK_NULL = 2'b00,
    FK_CTRL = 2'b01,
    FK_DATA = 2'b10,
    FK_RSVD = 2'b11
  } frame_kind_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SEL  = 2'b01,
    OP_WR   = 2'b10,
    OP_RD   = 2'b11
  } ctrl_op_e;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'b00,
    SRC_ZERO = 2'b01,
    SRC_BAT0 = 2'b10,
    SRC_BAT1 = 2'b11
  } src_sel_e;
endpackage

// File: rtl/fsb_frame_decode.sv
module fsb_frame_decode
  import fsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = DATA_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               is_null,
  output logic               is_ctrl,
  output logic               is_data,
  output logic [DATA_W-1:0]  payload
);
  frame_kind_e kind;

  always_comb begin
    kind    = frame_kind_e'(frm_data[FRAME_W-1 -: 2]);
    payload = frm_data[DATA_W-1:0];
    is_null = frm_valid && (kind == FK_NULL);
    is_ctrl = frm_valid && (kind == FK_CTRL);
    is_data = frm_valid && (kind == FK_DATA);
  end

  // R1: at most one frame kind strobe per cycle; reserved kind raises none
  p_one_kind_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_null, is_ctrl, is_data}));
  p_rsvd_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_data[FRAME_W-1 -: 2] == 2'b11) |-> !(is_null || is_ctrl || is_data));
endmodule

// File: rtl/fsb_reg_file.sv
module fsb_reg_file
  import fsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_CFG1 = 4'h1,
  parameter logic [ADDR_W-1:0] A_CFG2 = 4'h2,
  parameter logic [ADDR_W-1:0] A_CFG3 = 4'h7,
  parameter logic [DATA_W-1:0] CFG3_KEEP = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_null,
  input  logic              is_ctrl,
  input  logic              is_data,
  input  logic [DATA_W-1:0] payload,
  output logic [DATA_W-1:0] ctrl_byte,
  output logic [DATA_W-1:0] cfg1,
  output logic [DATA_W-1:0] cfg2,
  output logic [DATA_W-1:0] cfg3
);
  localparam int NREG = 3;

  logic [ADDR_W-1:0] addr;
  ctrl_op_e          op;
  logic              wr_ok;
  logic [DATA_W-1:0] bank [NREG];

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
  localparam addr_t ADDRS [NREG] = '{A_CFG1, A_CFG2, A_CFG3};
  localparam byte_t KEEPS [NREG] = '{{DATA_W{1'b1}}, {DATA_W{1'b1}}, CFG3_KEEP};

  assign addr  = ctrl_byte[ADDR_W-1:0];
  assign op    = ctrl_op_e'(ctrl_byte[DATA_W-1 -: 2]);
  assign wr_ok = is_data && (op == OP_WR);

  always_ff @(posedge clk) begin
    if (rst || is_null) ctrl_byte <= '0;
    else if (is_ctrl)   ctrl_byte <= payload;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst || is_null)
        bank[i] <= '0;
      else if (wr_ok && addr == ADDRS[i])
        bank[i] <= payload & KEEPS[i];
    end
  end

  assign cfg1 = bank[0];
  assign cfg2 = bank[1];
  assign cfg3 = bank[2];

  // R2: null frame leaves everything at zero
  p_null_clear_r2: assert property (@(posedge clk) disable iff (rst)
    is_null |=> (ctrl_byte == '0 && cfg1 == '0 && cfg2 == '0 && cfg3 == '0));
  // R3: control frame loads the control byte
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (rst)
    is_ctrl |=> ctrl_byte == $past(payload));
  // R10: data outside write operation changes nothing
  p_data_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (is_data && op != OP_WR) |=> ($stable(cfg1) && $stable(cfg2) && $stable(cfg3) && $stable(ctrl_byte)));
  // R8: address-7 register never holds bits outside the kept field
  p_cfg3_field_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg3 & ~CFG3_KEEP) == '0);
endmodule

// File: rtl/fsb_sample_fmt.sv
module fsb_sample_fmt
  import fsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SAMPLE_W = 12,
  parameter logic [SAMPLE_W-1:0] FULL_SCALE = 12'h7FF,
  parameter int HI_BIT = 2,
  localparam int HI_W = SAMPLE_W - DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] conv_sample,
  input  logic [DATA_W-1:0]   cfg2,
  input  logic [DATA_W-1:0]   cfg3,
  output logic [DATA_W-1:0]   adc_byte
);
  src_sel_e              src;
  logic [SAMPLE_W-1:0]   smp;
  logic                  hi_mode;

  assign src     = src_sel_e'(cfg2[DATA_W-1 -: 2]);
  assign hi_mode = cfg3[HI_BIT];

  always_comb begin
    case (src)
      SRC_EXT:  smp = conv_sample;
      SRC_ZERO: smp = '0;
      default:  smp = FULL_SCALE;
    endcase
  end

  always_comb begin
    if (hi_mode)
      adc_byte = {{(DATA_W-HI_W){1'b0}}, smp[SAMPLE_W-1:DATA_W]};
    else
      adc_byte = {~smp[DATA_W-1], smp[DATA_W-2:0]};
  end

  // R7: high mode never drives the upper payload bits
  p_hi_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    hi_mode |-> adc_byte[DATA_W-1:HI_W] == '0);
  // R5: internal node source reads as zero (inverted top bit in low mode)
  p_zero_src_r5: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_ZERO && !hi_mode) |-> adc_byte == {1'b1, {(DATA_W-1){1'b0}}});
endmodule

// File: rtl/fsb_read_port.sv
module fsb_read_port
  import fsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_ADC  = 4'h0,
  parameter logic [ADDR_W-1:0] A_CFG1 = 4'h1,
  parameter logic [ADDR_W-1:0] A_CFG2 = 4'h2,
  parameter logic [ADDR_W-1:0] A_CFG3 = 4'h7,
  parameter logic [ADDR_W-1:0] A_STAT = 4'hD,
  parameter logic [DATA_W-1:0] ID_CODE = 8'h43,
  parameter logic [DATA_W-1:0] ID_BYTE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] ctrl_byte,
  input  logic [DATA_W-1:0] adc_byte,
  input  logic [DATA_W-1:0] cfg1,
  input  logic [DATA_W-1:0] cfg2,
  input  logic [DATA_W-1:0] cfg3,
  input  logic              cold_start,
  input  logic              power_fail,
  output logic [DATA_W-1:0] rd_data
);
  ctrl_op_e          op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] rd_next;

  assign op     = ctrl_op_e'(ctrl_byte[DATA_W-1 -: 2]);
  assign addr   = ctrl_byte[ADDR_W-1:0];
  assign status = {{(DATA_W-2){1'b0}}, power_fail, cold_start};

  always_comb begin
    if      (addr == A_ADC)  reg_val = adc_byte;
    else if (addr == A_CFG1) reg_val = cfg1;
    else if (addr == A_CFG2) reg_val = cfg2;
    else if (addr == A_CFG3) reg_val = cfg3;
    else if (addr == A_STAT) reg_val = status;
    else                     reg_val = '0;
  end

  always_comb begin
    case (op)
      OP_SEL:  rd_next = (ctrl_byte == ID_CODE) ? ID_BYTE : '0;
      OP_RD:   rd_next = reg_val;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_data <= '0;
    else if (rd_strobe) rd_data <= rd_next;
  end

  // R11: output holds between strobes
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));
  // R4: only the identification code answers a select
  p_id_only_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && op == OP_SEL && ctrl_byte != ID_CODE) |=> rd_data == '0);
  // R9: status upper bits are zero
  p_status_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && op == OP_RD && addr == A_STAT) |=> rd_data[DATA_W-1:2] == '0);
endmodule

// File: rtl/fsb_adc_slave.sv
module fsb_adc_slave
  import fsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int SAMPLE_W = 12,
  parameter logic [SAMPLE_W-1:0] FULL_SCALE = 12'h7FF,
  parameter logic [DATA_W-1:0] ID_CODE = 8'h43,
  parameter logic [DATA_W-1:0] ID_BYTE = 8'h80,
  localparam int FRAME_W = DATA_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frm_valid,
  input  logic [FRAME_W-1:0]  frm_data,
  input  logic                rd_strobe,
  input  logic [SAMPLE_W-1:0] conv_sample,
  input  logic                cold_start,
  input  logic                power_fail,
  output logic [DATA_W-1:0]   rd_data
);
  localparam logic [ADDR_W-1:0] A_ADC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CFG3 = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(13);
  localparam int HI_BIT = 2;
  localparam logic [DATA_W-1:0] CFG3_KEEP = DATA_W'(6);

  logic              is_null, is_ctrl, is_data;
  logic [DATA_W-1:0] payload, ctrl_byte, cfg1, cfg2, cfg3, adc_byte;

  fsb_frame_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .is_null(is_null), .is_ctrl(is_ctrl), .is_data(is_data), .payload(payload)
  );

  fsb_reg_file #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .A_CFG1(A_CFG1), .A_CFG2(A_CFG2),
    .A_CFG3(A_CFG3), .CFG3_KEEP(CFG3_KEEP)
  ) u_regs (
    .clk(clk), .rst(rst), .is_null(is_null), .is_ctrl(is_ctrl), .is_data(is_data),
    .payload(payload), .ctrl_byte(ctrl_byte), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3)
  );

  fsb_sample_fmt #(
    .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .FULL_SCALE(FULL_SCALE), .HI_BIT(HI_BIT)
  ) u_fmt (
    .clk(clk), .rst(rst), .conv_sample(conv_sample), .cfg2(cfg2), .cfg3(cfg3),
    .adc_byte(adc_byte)
  );

  fsb_read_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .A_ADC(A_ADC), .A_CFG1(A_CFG1),
    .A_CFG2(A_CFG2), .A_CFG3(A_CFG3), .A_STAT(A_STAT),
    .ID_CODE(ID_CODE), .ID_BYTE(ID_BYTE)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .ctrl_byte(ctrl_byte),
    .adc_byte(adc_byte), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3),
    .cold_start(cold_start), .power_fail(power_fail), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_fsb_adc_slave.sv
`timescale 1ns/1ps
module sim_fsb_adc_slave;
  logic       clk = 0;
  logic       rst = 1;
  logic       frm_valid = 0;
  logic [9:0] frm_data = '0;
  logic       rd_strobe = 0;
  logic [11:0] conv_sample = '0;
  logic       cold_start = 0;
  logic       power_fail = 0;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsb_adc_slave u0 (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .rd_strobe(rd_strobe), .conv_sample(conv_sample), .cold_start(cold_start),
    .power_fail(power_fail), .rd_data(rd_data)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [1:0] kind, input logic [7:0] pl);
    @(negedge clk);
    frm_valid = 1; frm_data = {kind, pl};
    @(negedge clk);
    frm_valid = 0; frm_data = '0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    check(rd_data, exp, tag);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] v);
    frame(2'b01, {4'h8, a});
    frame(2'b10, v);
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
    frame(2'b01, {4'hC, a});
    rd(exp, tag);
  endtask

  function automatic logic [7:0] fmt(input int src, input bit hi, input int s);
    int e;
    e = (src == 0) ? s : (src == 1) ? 0 : 2047;
    if (hi) return 8'(e / 256);
    return 8'((e % 256) ^ 128);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rd_data, 8'h00, "R11 reset value");
    rst = 0;
    @(negedge clk);

    // R11 / R8 reset values read back
    rd(8'h00, "R11 strobe with op none");
    rd_reg(4'h1, 8'h00, "R8 cfg1 after reset");
    rd_reg(4'h2, 8'h00, "R8 cfg2 after reset");
    rd_reg(4'h7, 8'h00, "R8 cfg3 after reset");

    // R4: all select-operation control bytes
    for (int c = 8'h40; c <= 8'h7F; c++) begin
      frame(2'b01, 8'(c));
      rd((c == 8'h43) ? 8'h80 : 8'h00, "R4 select code");
    end

    // R8: exhaustive payload into address 7, field kept
    for (int v = 0; v < 256; v++) begin
      wr_reg(4'h7, 8'(v));
      rd_reg(4'h7, 8'(v & 6), "R8 cfg3 field");
    end
    wr_reg(4'h1, 8'hA5); rd_reg(4'h1, 8'hA5, "R8 cfg1 write");
    wr_reg(4'h2, 8'h3C); rd_reg(4'h2, 8'h3C, "R8 cfg2 write");

    // R10: sweep all addresses with known contents
    wr_reg(4'h1, 8'h5A); wr_reg(4'h2, 8'h00); wr_reg(4'h7, 8'h00);
    conv_sample = 12'h123;
    cold_start = 1; power_fail = 0;
    for (int a = 0; a < 16; a++) begin
      logic [7:0] e;
      case (a)
        0: e = 8'hA3;
        1: e = 8'h5A;
        2: e = 8'h00;
        7: e = 8'h00;
        13: e = 8'h01;
        default: e = 8'h00;
      endcase
      rd_reg(4'(a), e, "R10 address sweep");
    end

    // R10: data frames outside write, writes to unmapped address
    frame(2'b01, 8'hC1); frame(2'b10, 8'hFF);
    rd_reg(4'h1, 8'h5A, "R10 data during read op");
    frame(2'b01, 8'h41); frame(2'b10, 8'hFF);
    rd_reg(4'h1, 8'h5A, "R10 data during select op");
    frame(2'b01, 8'h01); frame(2'b10, 8'hFF);
    rd_reg(4'h1, 8'h5A, "R10 data during op none");
    wr_reg(4'h5, 8'hEE);
    rd_reg(4'h1, 8'h5A, "R10 unmapped write cfg1");
    rd_reg(4'h2, 8'h00, "R10 unmapped write cfg2");
    rd_reg(4'h7, 8'h00, "R10 unmapped write cfg3");
    rd_reg(4'h5, 8'h00, "R10 unmapped read");

    // R1: reserved kind ignored (would be select 0x43 if taken as control)
    frame(2'b01, 8'hC1);
    frame(2'b11, 8'h43);
    rd(8'h5A, "R1 reserved kind ignored");
    frame(2'b01, 8'h81);
    frame(2'b11, 8'h77);
    rd_reg(4'h1, 8'h5A, "R1 reserved kind no write");

    // R3: operation and address fields; bits 5:4 do not affect address
    frame(2'b01, 8'hF1);
    rd(8'h5A, "R3 read op with bits 5:4 set");

    // R5 R6 R7: source x mode x samples
    for (int src = 0; src < 4; src++) begin
      for (int hi = 0; hi < 2; hi++) begin
        wr_reg(4'h2, 8'(src << 6));
        wr_reg(4'h7, 8'(hi << 2));
        frame(2'b01, 8'hC0);
        for (int s = 0; s < 4096; s += 13) begin
          conv_sample = 12'(s);
          rd(fmt(src, hi[0], s), hi ? "R7 high nibble" : "R6 low byte inverted");
        end
        conv_sample = 12'hFFF;
        rd(fmt(src, hi[0], 4095), "R5 full-code sample");
      end
    end

    // R9: status flags
    for (int f = 0; f < 4; f++) begin
      cold_start = f[0]; power_fail = f[1];
      rd_reg(4'hD, 8'(f), "R9 status flags");
    end

    // R11: hold between strobes
    conv_sample = 12'h0FF; wr_reg(4'h2, 8'h00); wr_reg(4'h7, 8'h00);
    rd_reg(4'h0, 8'h7F, "R11 read before hold");
    conv_sample = 12'h000;
    repeat (3) @(negedge clk);
    check(rd_data, 8'h7F, "R11 hold without strobe");

    // R2: null frame clears control and registers
    wr_reg(4'h1, 8'h11); wr_reg(4'h2, 8'hC0); wr_reg(4'h7, 8'h06);
    frame(2'b01, 8'h43);
    frame(2'b00, 8'hFF);
    rd(8'h00, "R2 control byte cleared");
    rd_reg(4'h1, 8'h00, "R2 cfg1 cleared");
    rd_reg(4'h2, 8'h00, "R2 cfg2 cleared");
    rd_reg(4'h7, 8'h00, "R2 cfg3 cleared");
    conv_sample = 12'h234;
    rd_reg(4'h0, 8'hB4, "R2 source and mode back to defaults");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule